// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Memory Bus Arbiter

This block decides who drives a shared memory bus in each cycle. Three masters compete for it. The first is a display fetch engine. The second is the block's own refresh engine. The third is a CPU. Priority is fixed: display first, then refresh, then CPU. A master that holds a grant keeps it until it drops its request. A refresh keeps the bus until the DRAM sequencer reports that the command has finished. No master loses the bus in the middle of a transfer.

An interval timer marks refreshes as due. A 3-bit select code picks the period from a fixed set of system-clock counts. A due refresh is never thrown away. It goes into a saturating backlog counter. While the bus is free, the backlog is worked off one refresh at a time, with no gap between refreshes. When the display engine releases the bus, every stored refresh is issued before the CPU can take over. If a refresh comes due while the backlog is already full, a sticky overflow flag is set.

Top module: `mem_refresh_arbiter`

## Requirements
- R1: After reset, no grant is active, no refresh command is asserted, the backlog count is 0, the overflow flag is 0 and the interval code is 0.
- R2: The interval codes 0 to 7 select periods of 47, 78, 156, 312, 468, 624, 936 and 1248 clock cycles. A refresh comes due once per period. From reset with code 0, the first due refresh on an idle bus raises `ref_cmd` in the 47th cycle after reset is released.
- R3: A select write (`cfg_wr`=1) takes the new code and restarts the period from that cycle. No refresh comes due in the cycle of the write. The next one comes due a full new period later.
- R4: When the bus is free, the grant goes to the display engine if it requests. Otherwise it goes to refresh if the backlog is non-zero. Otherwise it goes to the CPU if it requests. At most one grant is high at a time.
- R5: A display or CPU grant stays high for as long as that master's request stays high. A due refresh does not take the bus from it.
- R6: Every refresh grant starts with `ref_cmd` high for exactly one cycle, and `ref_gnt` is high during that cycle. The refresh grant ends in the cycle after `ref_done` is seen. A `ref_done` that arrives in the command cycle is ignored.
- R7: Each due refresh adds one to `pend_cnt`.
- R8: Once the display engine releases the bus, all stored refreshes are issued back to back. The CPU is granted only when the backlog count is 0.
- R9: `pend_cnt` goes down by one on each accepted `ref_done`. A due refresh and a completion in the same cycle leave the count unchanged.
- R10: `pend_cnt` saturates at its maximum value, 2^PEND_W-1. A due refresh that arrives while the count is at the maximum, with no completion in the same cycle, sets `pend_ovf`. Once set, `pend_ovf` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the interval select code |
| cfg_sel | input | 3 | Interval select code |
| disp_req | input | 1 | Bus request from the display engine |
| disp_gnt | output | 1 | Bus grant to the display engine |
| cpu_req | input | 1 | Bus request from the CPU |
| cpu_gnt | output | 1 | Bus grant to the CPU |
| ref_gnt | output | 1 | High while the refresh engine owns the bus |
| ref_cmd | output | 1 | One-cycle refresh command to the DRAM sequencer |
| ref_done | input | 1 | Refresh completion from the DRAM sequencer |
| pend_cnt | output | PEND_W | Number of refreshes in the backlog |
| pend_ovf | output | 1 | Sticky flag: a due refresh arrived while the backlog was full |

## Verification
The bench builds the block with PEND_W=3, so the backlog fills at 7 entries. A display hold of a few hundred cycles at the 47-cycle period therefore drives the counter into saturation and sets the overflow flag. The drain of the full backlog then completes before the CPU is granted. The interval timer keeps its default width, so the real period values are checked directly. A behavioural model tracks elapsed cycles, backlog and bus owner, and it is compared with the outputs on every cycle.

// File: rtl/refarb_pkg.sv
package refarb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_DISP = 2'd1,
        OWN_REF  = 2'd2,
        OWN_CPU  = 2'd3
    } owner_e;

    function automatic logic [15:0] interval_cycles(input logic [2:0] code);
        logic [15:0] v;
        case (code)
            3'd0:    v = 16'd47;
            3'd1:    v = 16'd78;
            3'd2:    v = 16'd156;
            3'd3:    v = 16'd312;
            3'd4:    v = 16'd468;
            3'd5:    v = 16'd624;
            3'd6:    v = 16'd936;
            default: v = 16'd1248;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/refarb_timer.sv
module refarb_timer #(
    parameter int TMR_W = 11,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             due
);
    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [SEL_W-1:0] sel;
    } tmr_state_t;

    localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        due  = 1'b0;
        if (cfg_wr) begin
            st_d.sel = cfg_sel;
            st_d.tmr = TMR_W'(refarb_pkg::interval_cycles(cfg_sel));
        end else if (st_q.tmr == TMR_ONE) begin
            due      = 1'b1;
            st_d.tmr = TMR_W'(refarb_pkg::interval_cycles(st_q.sel));
        end else begin
            st_d.tmr = st_q.tmr - TMR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= '0;
            st_q.tmr <= TMR_W'(refarb_pkg::interval_cycles(3'd0));
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/refarb_backlog.sv
module refarb_backlog #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              due,
    input  logic              dec,
    output logic [PEND_W-1:0] pend_q_o,
    output logic              ovf_q_o,
    output logic              avail
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
        logic              ovf;
    } bl_state_t;

    bl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (due && !dec) begin
            if (st_q.cnt == PEND_MAX) st_d.ovf = 1'b1;
            else                      st_d.cnt = st_q.cnt + PEND_ONE;
        end else if (dec && !due) begin
            st_d.cnt = st_q.cnt - PEND_ONE;
        end
        avail = (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q_o = st_q.cnt;
    assign ovf_q_o  = st_q.ovf;
endmodule

// File: rtl/refarb_grant.sv
module refarb_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic disp_req,
    input  logic cpu_req,
    input  logic ref_done,
    input  logic ref_avail,
    output logic ref_fin,
    output logic disp_gnt,
    output logic ref_gnt,
    output logic cpu_gnt,
    output logic ref_cmd
);
    import refarb_pkg::*;

    typedef struct packed {
        owner_e owner;
        logic   cmd;
    } gr_state_t;

    gr_state_t st_d, st_q;
    logic      bus_free;

    always_comb begin
        st_d     = st_q;
        ref_fin  = (st_q.owner == OWN_REF) && !st_q.cmd && ref_done;
        bus_free = (st_q.owner == OWN_NONE)
                || ((st_q.owner == OWN_DISP) && !disp_req)
                || ((st_q.owner == OWN_CPU)  && !cpu_req)
                || ref_fin;
        st_d.cmd = 1'b0;
        if (bus_free) begin
            if (disp_req)       st_d.owner = OWN_DISP;
            else if (ref_avail) st_d.owner = OWN_REF;
            else if (cpu_req)   st_d.owner = OWN_CPU;
            else                st_d.owner = OWN_NONE;
            st_d.cmd = (st_d.owner == OWN_REF);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.owner <= OWN_NONE;
            st_q.cmd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_gnt = (st_q.owner == OWN_DISP);
    assign ref_gnt  = (st_q.owner == OWN_REF);
    assign cpu_gnt  = (st_q.owner == OWN_CPU);
    assign ref_cmd  = st_q.cmd;
endmodule

// File: rtl/mem_refresh_arbiter.sv
module mem_refresh_arbiter #(
    parameter int TMR_W  = 11,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic              disp_req,
    output logic              disp_gnt,
    input  logic              cpu_req,
    output logic              cpu_gnt,
    output logic              ref_gnt,
    output logic              ref_cmd,
    input  logic              ref_done,
    output logic [PEND_W-1:0] pend_cnt,
    output logic              pend_ovf
);
    localparam int SEL_W = 3;

    logic due;
    logic ref_fin;
    logic ref_avail;

    refarb_timer #(.TMR_W(TMR_W), .SEL_W(SEL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_sel (cfg_sel),
        .due     (due)
    );

    refarb_backlog #(.PEND_W(PEND_W)) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .due      (due),
        .dec      (ref_fin),
        .pend_q_o (pend_cnt),
        .ovf_q_o  (pend_ovf),
        .avail    (ref_avail)
    );

    refarb_grant u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_req  (disp_req),
        .cpu_req   (cpu_req),
        .ref_done  (ref_done),
        .ref_avail (ref_avail),
        .ref_fin   (ref_fin),
        .disp_gnt  (disp_gnt),
        .ref_gnt   (ref_gnt),
        .cpu_gnt   (cpu_gnt),
        .ref_cmd   (ref_cmd)
    );
endmodule

// File: rtl/refarb_checker.sv
module refarb_checker #(
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_req,
    input logic              cpu_req,
    input logic              disp_gnt,
    input logic              cpu_gnt,
    input logic              ref_gnt,
    input logic              ref_cmd,
    input logic [PEND_W-1:0] pend_cnt,
    input logic              pend_ovf
);
    localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_gnt, ref_gnt, cpu_gnt})); // R4
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd); // R6
    AST_CMD_WITH_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> ref_gnt); // R6
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_gnt && disp_req) |=> disp_gnt); // R5
    AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && cpu_req) |=> cpu_gnt); // R5
    AST_CPU_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_gnt) |-> (pend_cnt == '0)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ovf |=> pend_ovf); // R10
    AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_ovf) |-> (pend_cnt == FULL)); // R10
endmodule

bind mem_refresh_arbiter refarb_checker #(.PEND_W(PEND_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .disp_req (disp_req),
    .cpu_req  (cpu_req),
    .disp_gnt (disp_gnt),
    .cpu_gnt  (cpu_gnt),
    .ref_gnt  (ref_gnt),
    .ref_cmd  (ref_cmd),
    .pend_cnt (pend_cnt),
    .pend_ovf (pend_ovf)
);

// File: tb/mem_refresh_arbiter_bench.sv
`timescale 1ns/1ps
module mem_refresh_arbiter_bench;
    localparam int PW   = 3;
    localparam int MAXP = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic          disp_req = 1'b0;
    logic          cpu_req = 1'b0;
    logic          ref_done = 1'b0;
    logic          disp_gnt, cpu_gnt, ref_gnt, ref_cmd, pend_ovf;
    logic [PW-1:0] pend_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    mem_refresh_arbiter #(.PEND_W(PW)) u_mem_refresh_arbiter (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .disp_req(disp_req), .disp_gnt(disp_gnt), .cpu_req(cpu_req),
        .cpu_gnt(cpu_gnt), .ref_gnt(ref_gnt), .ref_cmd(ref_cmd),
        .ref_done(ref_done), .pend_cnt(pend_cnt), .pend_ovf(pend_ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int period_of(input int code);
        int t [8] = '{47, 78, 156, 312, 468, 624, 936, 1248};
        return t[code];
    endfunction

    // behavioural model: owner 0 none, 1 display, 2 refresh, 3 cpu
    int  m_age, m_ival, m_pend, m_own;
    bit  m_ovf, m_cmd;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_age = 0; m_ival = period_of(0); m_pend = 0; m_own = 0;
            m_ovf = 0; m_cmd = 0;
        end else begin
            bit due, fin, free;
            cyc++;
            due = 0;
            if (cfg_wr) begin
                m_ival = period_of(int'(cfg_sel));
                m_age = 0;
            end else begin
                m_age++;
                if (m_age == m_ival) begin due = 1; m_age = 0; end
            end
            fin = (m_own == 2) && !m_cmd && ref_done;
            if (fin) m_pend--;
            if (due) begin
                if (m_pend < MAXP) m_pend++;
                else m_ovf = 1;
            end
            free = (m_own == 0) || (m_own == 1 && !disp_req) ||
                   (m_own == 3 && !cpu_req) || fin;
            m_cmd = 0;
            if (free) begin
                m_own = disp_req ? 1 : (m_pend > 0) ? 2 : cpu_req ? 3 : 0;
                m_cmd = (m_own == 2);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 disp_gnt", int'(disp_gnt), int'(m_own == 1));
            check("R5 cpu_gnt", int'(cpu_gnt), int'(m_own == 3));
            check("R8 ref_gnt", int'(ref_gnt), int'(m_own == 2));
            check("R6 ref_cmd", int'(ref_cmd), int'(m_cmd));
            check("R7 R9 pend_cnt", int'(pend_cnt), m_pend);
            check("R10 pend_ovf", int'(pend_ovf), int'(m_ovf));
        end
    end

    // DRAM sequencer stand-in: done three cycles after the command
    int dcnt = 0;
    always @(negedge clk) begin
        ref_done = 1'b0;
        if (ref_cmd) dcnt = 3;
        else if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) ref_done = 1'b1;
        end
    end

    task automatic wait_cmd();
        @(negedge clk);
        while (!ref_cmd) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int wcyc, ncmd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 grants", int'({disp_gnt, ref_gnt, cpu_gnt}), 0);
        check("R1 cmd", int'(ref_cmd), 0);
        check("R1 pend", int'(pend_cnt), 0);
        check("R1 ovf", int'(pend_ovf), 0);
        // R2 first refresh at code 0
        while (!ref_cmd) @(negedge clk);
        check("R2 first refresh cycle", cyc, 47);
        repeat (20) @(negedge clk);
        // R3 select write restarts the period
        cfg_sel = 3'd2; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        wcyc = cyc;
        wait_cmd();
        check("R3 restart after write", cyc - wcyc, 156);
        wcyc = cyc;
        wait_cmd();
        check("R2 period code 2", cyc - wcyc, 156);
        repeat (10) @(negedge clk);
        // R4 priority on a free bus
        disp_req = 1'b1; cpu_req = 1'b1;
        @(negedge clk);
        check("R4 display wins", int'(disp_gnt), 1);
        check("R4 cpu waits", int'(cpu_gnt), 0);
        disp_req = 1'b0;
        @(negedge clk);
        check("R4 cpu after display", int'(cpu_gnt), 1);
        // R5 CPU not preempted by due refreshes
        ncmd = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!cpu_gnt) ncmd++;
        end
        check("R5 cpu held", ncmd, 0);
        check("R7 backlog under cpu", int'(pend_cnt >= 2), 1);
        cfg_sel = 3'd0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        // R10 saturation under a long display hold
        disp_req = 1'b1; cpu_req = 1'b0;
        repeat (500) @(negedge clk);
        check("R10 pend saturated", int'(pend_cnt), MAXP);
        check("R10 ovf set", int'(pend_ovf), 1);
        check("R5 display held", int'(disp_gnt), 1);
        // R8 drain before CPU
        disp_req = 1'b0; cpu_req = 1'b1;
        ncmd = 0;
        @(negedge clk);
        while (!cpu_gnt) begin
            if (ref_cmd) ncmd++;
            @(negedge clk);
        end
        check("R8 drained count", int'(ncmd >= MAXP), 1);
        check("R8 pend zero at cpu grant", int'(pend_cnt), 0);
        check("R10 ovf sticky", int'(pend_ovf), 1);
        repeat (50) @(negedge clk);
        cpu_req = 1'b0;
        repeat (100) @(negedge clk);
        finish_run();
    end
endmodule